// File: doc/BRIEF.md
# ADC Conversion Handshake Controller

This block runs an external 8-bit analog-to-digital converter through a start / end-of-conversion handshake. When a request arrives while the block is idle, it drives an active-high start pulse of fixed duration. It then waits for the converter's end-of-conversion line to drop and rise again, and latches the 8-bit result. A single-cycle valid strobe goes out with the result. If end-of-conversion does not come back within twice the nominal conversion time, the block raises an error flag and returns to idle.

The start pulse width (2 µs) and the nominal conversion time (20 µs) are given in nanoseconds as parameters. The clock frequency is also a parameter. Both cycle counts are derived from these values and rounded up to whole clock cycles. End-of-conversion is asynchronous to the clock and passes through a synchronizer before the control logic uses it.

Top module: `adc_conv_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, start_o, busy_o, valid_o, err_o and data_o are all zero.
- R2: A request seen while idle makes start_o high on the next cycle. start_o stays high for exactly PULSE = ceil(START_NS * CLK_HZ / 1e9) cycles, and a request made during the pulse does not change its width.
- R3: busy_o is high from the first cycle of the start pulse until the cycle in which valid_o or err_o is set, and it is low in that cycle.
- R4: End-of-conversion counts only after the start pulse has ended and the synchronized line has been seen low. A line that stays high through the whole conversion produces no capture and leads to a timeout.
- R5: The result is registered on the first clock edge at which the synchronized end-of-conversion is high. When eoc_i rises between two clock edges, valid_o is high after the third following edge, and data_o equals data_i.
- R6: valid_o lasts exactly one cycle. data_o holds the last captured value until the next capture, even through a timeout.
- R7: Let TMO = ceil(2 * CONV_NS * CLK_HZ / 1e9). If no capture happens, err_o rises and busy_o falls TMO cycles after start_o falls. A capture on that last cycle takes priority over the timeout.
- R8: err_o stays high in idle until the next accepted request, which clears it in the same cycle that start_o rises.
- R9: A request made while a conversion is in progress is ignored: no new start pulse appears and the conversion's timing is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Conversion request, sampled each cycle |
| eoc_i | input | 1 | End-of-conversion from the converter (asynchronous) |
| data_i | input | DATA_W | Converter result lines |
| start_o | output | 1 | Start-of-conversion pulse to the converter |
| busy_o | output | 1 | A conversion is in progress |
| data_o | output | DATA_W | Last captured result |
| valid_o | output | 1 | One-cycle strobe: data_o was just updated |
| err_o | output | 1 | End-of-conversion did not arrive in time |

## Verification
The bench builds the block with CLK_HZ = 3,100,000. This gives a 7-cycle start pulse, where 6.2 cycles are rounded up, and a 124-cycle timeout, so every timer boundary is reached in a short run. With a window that small, the bench can sweep the arrival delay of end-of-conversion across every cycle of the wait, from zero up to the last cycle that still captures, and then one cycle past it into the timeout. Separate runs cover a line stuck high, a late low phase, and requests made during the pulse and during the wait.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

    // Sequencer phases
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PULSE = 2'd1,
        PH_LOW   = 2'd2,
        PH_HIGH  = 2'd3
    } phase_t;

    // Convert a duration in nanoseconds into whole clock cycles, rounding up
    function automatic int ns_to_cycles(input longint hz, input longint ns);
        longint prod;
        prod = hz * ns;
        return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_eoc_sync.sv
module adc_eoc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_regs_t;

    sync_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        r_d.chain[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            r_d.chain[i] = r_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sync_o = r_q.chain[STAGES-1];

endmodule

// File: rtl/adc_interval_timer.sv
module adc_interval_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          dec_i,
    output logic          zero_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } timer_regs_t;

    timer_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            r_d.cnt = load_val_i;
        end else if (dec_i) begin
            r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign zero_o = (r_q.cnt == '0);

    // R7
    timer_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i) |-> !zero_o);

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_ctrl_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int CW        = 8,
    parameter int PULSE_CYC = 4,
    parameter int TMO_CYC   = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              eoc_s_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              tmr_zero_i,
    output logic              tmr_load_o,
    output logic [CW-1:0]     tmr_val_o,
    output logic              tmr_dec_o,
    output logic              start_o,
    output logic              busy_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              err_o
);

    localparam logic [CW-1:0] PULSE_LOAD = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] TMO_LOAD   = CW'(TMO_CYC - 1);

    typedef struct packed {
        phase_t            phase;
        logic              start;
        logic              valid;
        logic              err;
        logic [DATA_W-1:0] data;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.valid  = 1'b0;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        tmr_dec_o  = 1'b0;

        unique case (r_q.phase)
            PH_IDLE: begin
                if (req_i) begin
                    r_d.phase  = PH_PULSE;
                    r_d.start  = 1'b1;
                    r_d.err    = 1'b0;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = PULSE_LOAD;
                end
            end
            PH_PULSE: begin
                if (tmr_zero_i) begin
                    r_d.phase  = PH_LOW;
                    r_d.start  = 1'b0;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = TMO_LOAD;
                end else begin
                    tmr_dec_o = 1'b1;
                end
            end
            PH_LOW, PH_HIGH: begin
                if (r_q.phase == PH_HIGH && eoc_s_i) begin
                    r_d.data  = data_i;
                    r_d.valid = 1'b1;
                    r_d.phase = PH_IDLE;
                end else if (tmr_zero_i) begin
                    r_d.err   = 1'b1;
                    r_d.phase = PH_IDLE;
                end else begin
                    tmr_dec_o = 1'b1;
                    if (r_q.phase == PH_LOW && !eoc_s_i) begin
                        r_d.phase = PH_HIGH;
                    end
                end
            end
            default: r_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{phase: PH_IDLE, start: 1'b0, valid: 1'b0, err: 1'b0, data: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign start_o = r_q.start;
    assign busy_o  = (r_q.phase != PH_IDLE);
    assign data_o  = r_q.data;
    assign valid_o = r_q.valid;
    assign err_o   = r_q.err;

    // R4
    no_capture_before_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_LOW) |=> !valid_o);

    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(data_o));

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
    import adc_ctrl_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int START_NS    = 2_000,
    parameter int CONV_NS     = 20_000,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              eoc_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              start_o,
    output logic              busy_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              err_o
);

    localparam int PULSE_CYC = max_int(1, ns_to_cycles(longint'(CLK_HZ), longint'(START_NS)));
    localparam int TMO_CYC   = max_int(1, ns_to_cycles(longint'(CLK_HZ), 2 * longint'(CONV_NS)));
    localparam int MAX_CYC   = max_int(PULSE_CYC, TMO_CYC);
    localparam int CW        = $clog2(MAX_CYC + 1);

    logic          eoc_s;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_dec;
    logic          tmr_zero;

    adc_eoc_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (eoc_i),
        .sync_o  (eoc_s)
    );

    adc_interval_timer #(
        .CW (CW)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .dec_i      (tmr_dec),
        .zero_o     (tmr_zero)
    );

    adc_conv_seq #(
        .DATA_W    (DATA_W),
        .CW        (CW),
        .PULSE_CYC (PULSE_CYC),
        .TMO_CYC   (TMO_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .eoc_s_i    (eoc_s),
        .data_i     (data_i),
        .tmr_zero_i (tmr_zero),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .tmr_dec_o  (tmr_dec),
        .start_o    (start_o),
        .busy_o     (busy_o),
        .data_o     (data_o),
        .valid_o    (valid_o),
        .err_o      (err_o)
    );

    // R3
    start_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> busy_o);

    // R9
    start_only_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_o) |-> ($past(req_i) && !$past(busy_o)));

    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R7
    err_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> (!valid_o && !busy_o));

    // R8
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_o) |-> $rose(start_o));

endmodule

// File: tb/sim_adc_conv_ctrl.sv
module sim_adc_conv_ctrl;

    localparam int     CLK_PERIOD = 10;
    localparam int     P_CLK_HZ   = 3_100_000;
    localparam int     P_START_NS = 2_000;
    localparam int     P_CONV_NS  = 20_000;
    localparam longint NS_PER_S   = 1_000_000_000;
    localparam int     EXP_PULSE  = int'((longint'(P_CLK_HZ) * P_START_NS + NS_PER_S - 1) / NS_PER_S);
    localparam int     EXP_TMO    = int'((longint'(P_CLK_HZ) * 2 * P_CONV_NS + NS_PER_S - 1) / NS_PER_S);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_i = 1'b0;
    logic       eoc_i = 1'b1;
    logic [7:0] data_i = '0;
    logic       start_o, busy_o, valid_o, err_o;
    logic [7:0] data_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_conv_ctrl #(
        .CLK_HZ   (P_CLK_HZ),
        .START_NS (P_START_NS),
        .CONV_NS  (P_CONV_NS),
        .DATA_W   (8)
    ) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .eoc_i   (eoc_i),
        .data_i  (data_i),
        .start_o (start_o),
        .busy_o  (busy_o),
        .data_o  (data_o),
        .valid_o (valid_o),
        .err_o   (err_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Issue a request; ADC model lowers EOC during the pulse if lower is set.
    task automatic request(input bit lower, input bit poke, output int width);
        @(negedge clk) req_i = 1'b1;
        @(negedge clk) req_i = 1'b0;
        check(start_o == 1'b1, "R2 start after request", int'(start_o), 1);
        check(busy_o == 1'b1, "R3 busy at start", int'(busy_o), 1);
        check(err_o == 1'b0, "R8 err cleared by request", int'(err_o), 0);
        width = 0;
        while (start_o && width < EXP_PULSE + 5) begin
            width++;
            if (lower) eoc_i = 1'b0;
            req_i = poke && (width == 2);
            @(negedge clk);
        end
        req_i = 1'b0;
    endtask

    // Starts at the negedge where start_o was first seen low (n = 0).
    task automatic await(input int d, input bit raise, input int drop_at, input bit poke,
                         input logic [7:0] val, output int n, output bit gv, output bit ge,
                         output bit saw_start);
        n = 0; gv = 1'b0; ge = 1'b0; saw_start = 1'b0;
        while (n < EXP_TMO + 6) begin
            if (n == drop_at) eoc_i = 1'b0;
            if (raise && n == d) begin
                data_i = val;
                eoc_i  = 1'b1;
            end
            req_i = poke && (n == 1);
            @(negedge clk);
            n++;
            if (start_o) saw_start = 1'b1;
            if (valid_o) gv = 1'b1;
            if (err_o)   ge = 1'b1;
            if (gv || ge) break;
        end
        req_i = 1'b0;
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
        end
    end

    initial begin
        int w, n;
        bit gv, ge, ss;
        logic [7:0] last;

        // R1 reset state
        repeat (3) @(negedge clk);
        check({start_o, busy_o, valid_o, err_o} == 4'b0, "R1 flags in reset",
              int'({start_o, busy_o, valid_o, err_o}), 0);
        check(data_o == 8'd0, "R1 data in reset", int'(data_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check({start_o, busy_o, valid_o, err_o} == 4'b0, "R1 flags after reset",
              int'({start_o, busy_o, valid_o, err_o}), 0);

        // R5 sweep of arrival delay over every capturing cycle
        for (int d = 0; d <= EXP_TMO - 3; d++) begin
            logic [7:0] v;
            v = 8'((d * 37 + 5) & 8'hFF);
            request(1'b1, 1'b0, w);
            check(w == EXP_PULSE, "R2 pulse width", w, EXP_PULSE);
            await(d, 1'b1, -1, 1'b0, v, n, gv, ge, ss);
            check(gv && n == d + 3, "R5 capture latency", n, d + 3);
            check(data_o == v, "R5 captured data", int'(data_o), int'(v));
            check(busy_o == 1'b0, "R3 busy low at valid", int'(busy_o), 0);
            check(err_o == 1'b0, "R7 no error on capture", int'(err_o), 0);
            @(negedge clk);
            check(valid_o == 1'b0, "R6 valid one cycle", int'(valid_o), 0);
            check(data_o == v, "R6 data held", int'(data_o), int'(v));
        end
        last = data_o;

        // R7 one cycle too late: timeout wins
        request(1'b1, 1'b0, w);
        await(EXP_TMO - 2, 1'b1, -1, 1'b0, 8'hA5, n, gv, ge, ss);
        check(ge && !gv && n == EXP_TMO, "R7 timeout cycle", n, EXP_TMO);
        check(busy_o == 1'b0, "R3 busy low at timeout", int'(busy_o), 0);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(valid_o == 1'b0, "R7 late eoc ignored in idle", int'(valid_o), 0);
            check(err_o == 1'b1, "R8 err held", int'(err_o), 1);
        end
        check(data_o == last, "R6 data kept over timeout", int'(data_o), int'(last));

        // R4 eoc stuck high: no capture, timeout
        eoc_i = 1'b1;
        request(1'b0, 1'b0, w);
        await(0, 1'b0, -1, 1'b0, 8'h00, n, gv, ge, ss);
        check(ge && !gv, "R4 stuck high gives no capture", int'(gv), 0);
        check(n == EXP_TMO, "R4 stuck high timeout cycle", n, EXP_TMO);

        // R4 low phase appears after the pulse: latency still from final rise
        eoc_i = 1'b1;
        request(1'b0, 1'b0, w);
        await(5, 1'b1, 0, 1'b0, 8'h3C, n, gv, ge, ss);
        check(gv && n == 8, "R4 late low then capture", n, 8);
        check(data_o == 8'h3C, "R4 late low data", int'(data_o), 8'h3C);

        // R9 request during pulse and during wait
        request(1'b1, 1'b1, w);
        check(w == EXP_PULSE, "R9 pulse width with request", w, EXP_PULSE);
        await(10, 1'b1, -1, 1'b1, 8'hC3, n, gv, ge, ss);
        check(!ss, "R9 no restart while busy", int'(ss), 0);
        check(gv && n == 13, "R9 timing unchanged", n, 13);
        check(data_o == 8'hC3, "R9 data", int'(data_o), 8'hC3);
        repeat (3) @(negedge clk);
        check(!busy_o && !start_o, "R9 idle after ignored request", int'(busy_o), 0);

        done = 1'b1;
        summary();
    end

endmodule